// File: doc/BRIEF.md
# Ten-Source Interrupt Controller with IRQ/FIQ Steering

This block gathers ten peripheral interrupt lines and reduces them to two CPU requests: an ordinary interrupt request and a fast interrupt request. Software sets each source's enable bit through one write-one-to-set address and clears it through another. A per-source steering bit sends an enabled source to one output or the other. Each of the two external lines can be set to active low. For bring-up and diagnostics, a test pattern register can take the place of the real inputs.

Source numbering, by bit: 0 timer, 1 first serial port, 2 second serial port, 3 USB host, 4 external line A, 5 external line B, 6 to 8 three PCI slots, 9 Ethernet switch. Access uses a simple 32-bit register bus with one-cycle writes and combinational reads. The inputs are level sensitive and are assumed to be synchronous to `clk` already.

Top module: `intsrc_ctrl`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are 0, and reads of the enable (0x08), steering (0x14), polarity (0x24) and test-select (0x20) offsets return 0.
- R2: Writing to offset 0x08 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Write-data bits 10 and above are ignored. A read of 0x08 returns the current enable mask.
- R3: Writing to offset 0x0C clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A write of 0 changes nothing.
- R4: A read of offset 0x04 returns the ten effective source levels in bits 9..0, with bits 31..10 read as 0. Each level is the selected input after polarity correction, whether or not the source is enabled.
- R5: A read of offset 0x00 returns the effective levels AND enable AND NOT steering. `irq_o` is 1 when any bit of that value is 1.
- R6: A read of offset 0x18 returns the effective levels AND enable AND steering, so a steering bit of 1 selects the fast output. `fiq_o` is 1 when any bit of that value is 1. No source appears in both 0x00 and 0x18.
- R7: Offset 0x24 is the polarity register. A bit of 1 makes its source active low. Only bits 4 and 5 can be written; every other bit always reads 0.
- R8: When bit 0 of offset 0x20 is 0, the pattern held at offset 0x1C has no effect and the real inputs are used. When the bit is 1, that pattern replaces the real inputs before polarity correction.
- R9: `irq_o` and `fiq_o` are registered. They show, one clock edge later, the condition formed from the inputs and register contents present before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Peripheral interrupt lines, bit n is source n |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two things can happen in the same cycle: a source line rises, and software clears that source's enable bit. The bench raises input bit 3 in the same cycle as a write of 1 to bit 3 at offset 0x0C, with every other source idle. Because the output register samples the old enable mask together with the new input, `irq_o` must show a single-cycle pulse and then drop one edge later. The bench checks both cycles. A related collision is also covered: switching the test-select bit while the real inputs and the test pattern differ must change the raw status at once.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
    localparam int NSRC   = 10;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    // Sources whose polarity may be inverted.
    localparam logic [NSRC-1:0] POL_CAPABLE = 10'h030;

    localparam logic [ADDR_W-1:0] OFS_MASKED = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ENSET  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ENCLR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STEER  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_FAST   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_TPAT   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TSEL   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_POL    = 6'h24;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] steer;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] tpat;
        logic            tsel;
    } cfg_t;

    typedef struct packed {
        logic irq;
        logic fiq;
    } req_t;
endpackage

// File: rtl/intsrc_regs.sv
module intsrc_regs
    import intsrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NSRC-1:0]   wbits,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (waddr)
                OFS_ENSET: cfg_d.en    = cfg_q.en | wbits;
                OFS_ENCLR: cfg_d.en    = cfg_q.en & ~wbits;
                OFS_STEER: cfg_d.steer = wbits;
                OFS_POL:   cfg_d.pol   = wbits & POL_CAPABLE;
                OFS_TPAT:  cfg_d.tpat  = wbits;
                OFS_TSEL:  cfg_d.tsel  = wbits[0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/intsrc_route.sv
module intsrc_route
    import intsrc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cfg_t            cfg,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] norm_o,
    output logic [NSRC-1:0] fast_o,
    output req_t            req_o
);
    req_t            req_d, req_q;
    logic [NSRC-1:0] pick;

    always_comb begin
        pick   = cfg.tsel ? cfg.tpat : src_i;
        raw_o  = pick ^ cfg.pol;
        norm_o = raw_o & cfg.en & ~cfg.steer;
        fast_o = raw_o & cfg.en & cfg.steer;
        req_d.irq = |norm_o;
        req_d.fiq = |fast_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl
    import intsrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    cfg_t            cfg;
    req_t            req;
    logic [NSRC-1:0] raw_w, norm_w, fast_w;
    logic [NSRC-1:0] en_w, steer_w, pol_w;

    intsrc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_sel & bus_wr),
        .waddr (bus_addr),
        .wbits (bus_wdata[NSRC-1:0]),
        .cfg_o (cfg)
    );

    intsrc_route u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .src_i  (src_i),
        .raw_o  (raw_w),
        .norm_o (norm_w),
        .fast_o (fast_w),
        .req_o  (req)
    );

    assign en_w    = cfg.en;
    assign steer_w = cfg.steer;
    assign pol_w   = cfg.pol;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MASKED: bus_rdata[NSRC-1:0] = norm_w;
            OFS_RAW:    bus_rdata[NSRC-1:0] = raw_w;
            OFS_ENSET:  bus_rdata[NSRC-1:0] = cfg.en;
            OFS_STEER:  bus_rdata[NSRC-1:0] = cfg.steer;
            OFS_FAST:   bus_rdata[NSRC-1:0] = fast_w;
            OFS_TPAT:   bus_rdata[NSRC-1:0] = cfg.tpat;
            OFS_TSEL:   bus_rdata[0]        = cfg.tsel;
            OFS_POL:    bus_rdata[NSRC-1:0] = cfg.pol;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o = req.irq;
    assign fiq_o = req.fiq;
endmodule

// File: rtl/intsrc_chk.sv
module intsrc_chk
    import intsrc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   en,
    input logic [NSRC-1:0]   pol,
    input logic [NSRC-1:0]   norm,
    input logic [NSRC-1:0]   fast,
    input logic              irq_o,
    input logic              fiq_o
);
    AST_ENSET_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_ENSET) |=>
        ((en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R2
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(en)); // R2
    AST_ENCLR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_ENCLR) |=>
        ((en & $past(bus_wdata[NSRC-1:0])) == '0)); // R3
    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (norm & fast) == '0); // R6
    AST_POL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (pol & ~POL_CAPABLE) == '0); // R7
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|norm))); // R9
    AST_FIQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|fast))); // R9
endmodule

bind intsrc_ctrl intsrc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en        (en_w),
    .pol       (pol_w),
    .norm      (norm_w),
    .fast      (fast_w),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/sim_intsrc_ctrl.sv
module sim_intsrc_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    intsrc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        check("R1 fiq", {31'd0, fiq_o}, 32'd0);
        rd_chk("R1 enable", 6'h08, 32'd0);
        rd_chk("R1 steer", 6'h14, 32'd0);
        rd_chk("R1 polarity", 6'h24, 32'd0);
        rd_chk("R1 select", 6'h20, 32'd0);
    endtask

    task automatic t_enable();
        wr(6'h08, 32'h005);
        rd_chk("R2 set", 6'h08, 32'h005);
        wr(6'h08, 32'h100);
        rd_chk("R2 zeros keep", 6'h08, 32'h105);
        wr(6'h08, 32'hFFFF_FC00);
        rd_chk("R2 upper ignored", 6'h08, 32'h105);
    endtask

    task automatic t_clear();
        wr(6'h0C, 32'h004);
        rd_chk("R3 clear", 6'h08, 32'h101);
        wr(6'h0C, 32'h000);
        rd_chk("R3 zero write", 6'h08, 32'h101);
        wr(6'h0C, 32'h3FF);
        rd_chk("R3 clear all", 6'h08, 32'h000);
    endtask

    task automatic t_raw();
        @(negedge clk); src_i = 10'h2A5;
        rd_chk("R4 raw", 6'h04, 32'h2A5);
        rd_chk("R5 masked none", 6'h00, 32'h000);
        settle();
        check("R5 irq idle", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_irq();
        wr(6'h08, 32'h020);
        settle();
        check("R5 irq", {31'd0, irq_o}, 32'd1);
        rd_chk("R5 masked", 6'h00, 32'h020);
        @(negedge clk); src_i = 10'h000;
        #1;
        check("R9 held before edge", {31'd0, irq_o}, 32'd1);
        settle();
        check("R9 drop after edge", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_fiq();
        @(negedge clk); src_i = 10'h021;
        wr(6'h08, 32'h001);
        wr(6'h14, 32'h001);
        settle();
        check("R6 fiq", {31'd0, fiq_o}, 32'd1);
        check("R5 irq from bit5", {31'd0, irq_o}, 32'd1);
        rd_chk("R6 fast status", 6'h18, 32'h001);
        rd_chk("R6 masked excl", 6'h00, 32'h020);
        wr(6'h0C, 32'h020);
        settle();
        check("R6 irq off", {31'd0, irq_o}, 32'd0);
        check("R6 fiq stays", {31'd0, fiq_o}, 32'd1);
        wr(6'h14, 32'h000);
        wr(6'h0C, 32'h3FF);
        @(negedge clk); src_i = 10'h000;
    endtask

    task automatic t_level();
        wr(6'h08, 32'h3FF);
        wr(6'h24, 32'h3FF);
        rd_chk("R7 only ext bits", 6'h24, 32'h030);
        rd_chk("R7 raw inverted", 6'h04, 32'h030);
        settle();
        check("R7 irq low-active", {31'd0, irq_o}, 32'd1);
        @(negedge clk); src_i = 10'h030;
        rd_chk("R7 raw released", 6'h04, 32'h000);
        wr(6'h24, 32'h000);
        rd_chk("R7 back high", 6'h04, 32'h030);
        @(negedge clk); src_i = 10'h000;
    endtask

    task automatic t_test();
        @(negedge clk); src_i = 10'h3FF;
        wr(6'h1C, 32'h00C);
        rd_chk("R8 pattern ignored", 6'h04, 32'h3FF);
        wr(6'h20, 32'h001);
        rd_chk("R8 select read", 6'h20, 32'h001);
        rd_chk("R8 pattern used", 6'h04, 32'h00C);
        wr(6'h24, 32'h010);
        rd_chk("R8 polarity after pattern", 6'h04, 32'h01C);
        wr(6'h24, 32'h000);
        wr(6'h20, 32'h000);
        rd_chk("R8 real again", 6'h04, 32'h3FF);
        @(negedge clk); src_i = 10'h000;
        settle();
    endtask

    task automatic t_collide();
        wr(6'h08, 32'h3FF);
        settle();
        check("R9 idle", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        src_i = 10'h008;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h008;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R9 collide pulse", {31'd0, irq_o}, 32'd1);
        settle();
        check("R3 collide cleared", {31'd0, irq_o}, 32'd0);
        rd_chk("R3 collide mask", 6'h08, 32'h3F7);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_clear();
        t_raw();
        t_irq();
        t_fiq();
        t_level();
        t_test();
        t_collide();
        done = 1'b1;
        finish_run();
    end
endmodule